// File: doc/BRIEF.md
# Dual Reload Interval Timer

This peripheral gives an operating system its time base. It holds a 32-bit free-running timestamp counter and two independent down-counting interval timers, all of which advance only on clock cycles where the `tick` enable input is high. A simple 32-bit register bus is used to program and read the block. Each interval timer has a reload register. Its two lowest bits are control flags: bit 0 enables the timer and bit 1 selects one-shot operation. The remaining bits give the reload value, so every effective interval is a multiple of four ticks.

When a timer expires, it sets its own pending flag in a shared status register. A periodic timer then reloads and keeps counting. A one-shot timer clears its own enable flag and halts. Software clears a pending flag by writing a one to that status bit. Each timer has a dedicated interrupt output that follows its pending flag. A wrap of the timestamp counter is also recorded as a pending flag in the status register, but it has no interrupt line.

Word offsets in the register map are:

| Offset | Register |
|--------|----------|
| 0x00 | Timestamp counter, writable |
| 0x04 | Timer 1 current count, read-only |
| 0x08 | Timer 1 reload register |
| 0x0C | Timer 2 current count, read-only |
| 0x10 | Timer 2 reload register |
| 0x20 | Status register |

Reads are combinational from `bus_addr`. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, every register reads zero and both `tmr_irq` bits are low.
- R2: The timestamp counter (offset 0x00) adds one on each clock edge where `tick` is high. It holds its value when `tick` is low.
- R3: A write to offset 0x00 loads the timestamp with the written data, so writing zero restarts it from zero. The write takes priority over a tick in the same cycle.
- R4: When the timestamp counter steps from all ones to zero, it sets status bit 2.
- R5: A reload register (0x08 for timer 1, 0x10 for timer 2) reads back exactly as written. Bit 0 is the enable flag and bit 1 the one-shot flag. The counter uses the written value with bits [1:0] forced to zero.
- R6: An enabled periodic timer (bit 1 = 0) decrements by one per tick. A tick that arrives while the count is 0 or 1 is an expiry: it reloads the masked reload value and sets the timer's pending flag (status bit 0 for timer 1, bit 1 for timer 2). The period is therefore the masked reload value in ticks.
- R7: On expiry in one-shot mode, the timer sets its pending flag, clears bit 0 of its reload register, drops its count to zero and stops counting.
- R8: A reload write to a disabled timer loads the count with the masked value at once. A reload write to an enabled timer leaves the running count alone, and the new value is loaded at the next expiry.
- R9: While a timer's enable bit is zero (for example after writing zero to its reload register), its count holds at its current value through any number of ticks.
- R10: At offset 0x20, writing a one to a status bit clears that flag and writing a zero leaves it unchanged. A new pending event in the same cycle as a clear wins. Bits 3 and 4 always read zero.
- R11: `tmr_irq[0]` and `tmr_irq[1]` rise on the clock edge at which their timer expires. Each stays high until software clears the matching status bit.
- R12: Writes to the count offsets 0x04 and 0x0C have no effect. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable; all counters advance on edges where it is high |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tmr_irq | output | 2 | Interrupt per timer; bit 0 timer 1, bit 1 timer 2 |

## Verification
Timer 1 is run periodically with a reload of 12 over two full periods. This separates a true reload from a single expiry and shows the off-by-one at the expiry boundary. Timer 2 is run in one-shot mode and then ticked well past its interval, which tells a halted timer apart from one that silently keeps reloading. A reload is written in the middle of a running interval, and again while the timer is disabled, to tell deferred loading from immediate loading. The status register is exercised with zero writes, writes to other bits, and a clear issued in the same cycle as an expiry, which shows whether set or clear has priority. The timestamp is preset near all ones to expose the wrap and its flag without a long run.

// File: rtl/dit_pkg.sv
package dit_pkg;

  // Bus and counter geometry
  localparam int DW     = 32;
  localparam int AW     = 8;
  localparam int NT     = 2;            // number of interval timers
  localparam int ST_W   = 5;            // architected status width
  localparam int PEND_W = NT + 1;       // timers plus timestamp wrap

  // Reload register flag positions
  localparam int RL_EN  = 0;
  localparam int RL_ONE = 1;

  // Status bit of the timestamp wrap flag (timers occupy bits 0..NT-1)
  localparam int ST_TSW = NT;

  // Register offsets (bytes)
  localparam int OFF_TS   = 'h00;
  localparam int OFF_STAT = 'h20;

  function automatic int cnt_off(int idx);
    return 4 + 8 * idx;
  endfunction

  function automatic int rl_off(int idx);
    return 8 + 8 * idx;
  endfunction

  // Counting value used by a timer: flag bits read as zero
  function automatic logic [DW-1:0] eff_reload(logic [DW-1:0] raw);
    return {raw[DW-1:2], 2'b00};
  endfunction

  // A tick at this count ends the interval
  function automatic logic at_expiry(logic [DW-1:0] cnt);
    return (cnt[DW-1:1] == '0);
  endfunction

  function automatic logic [DW-1:0] step_down(logic [DW-1:0] cnt);
    return cnt - DW'(1);
  endfunction

  function automatic logic ts_wraps(logic [DW-1:0] ts);
    return (ts == '1);
  endfunction

endpackage

// File: rtl/dit_regdec.sv
module dit_regdec
  import dit_pkg::*;
#(
  parameter int A_W = AW,
  parameter int D_W = DW,
  parameter int N_T = NT
) (
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [A_W-1:0]           bus_addr,
  input  logic [D_W-1:0]           ts_q,
  input  logic [N_T-1:0][D_W-1:0]  cnt_q,
  input  logic [N_T-1:0][D_W-1:0]  rl_q,
  input  logic [D_W-1:0]           stat_word,
  output logic                     wr_ts,
  output logic [N_T-1:0]           wr_rl,
  output logic                     wr_st,
  output logic [D_W-1:0]           rdata
);

  logic wr_any;
  assign wr_any = bus_sel & bus_wr;

  assign wr_ts = wr_any & (bus_addr == A_W'(OFF_TS));
  assign wr_st = wr_any & (bus_addr == A_W'(OFF_STAT));

  for (genvar g = 0; g < N_T; g++) begin : g_rl_dec
    assign wr_rl[g] = wr_any & (bus_addr == A_W'(rl_off(g)));
  end

  always_comb begin
    rdata = '0;
    if (bus_addr == A_W'(OFF_TS))   rdata = ts_q;
    if (bus_addr == A_W'(OFF_STAT)) rdata = stat_word;
    for (int i = 0; i < N_T; i++) begin
      if (bus_addr == A_W'(cnt_off(i))) rdata = cnt_q[i];
      if (bus_addr == A_W'(rl_off(i)))  rdata = rl_q[i];
    end
  end

endmodule

// File: rtl/dit_tstamp.sv
module dit_tstamp
  import dit_pkg::*;
#(
  parameter int D_W = DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wr_ts,
  input  logic [D_W-1:0] wdata,
  output logic [D_W-1:0] ts_q,
  output logic           ts_wrap
);

  assign ts_wrap = tick & ~wr_ts & ts_wraps(ts_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ts_q <= '0;
    else if (wr_ts) ts_q <= wdata;
    else if (tick)  ts_q <= ts_q + D_W'(1);
  end

endmodule

// File: rtl/dit_interval.sv
module dit_interval
  import dit_pkg::*;
#(
  parameter int D_W = DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           rl_wr,
  input  logic [D_W-1:0] wdata,
  output logic [D_W-1:0] rl_q,
  output logic [D_W-1:0] cnt_q,
  output logic           expire
);

  logic enabled;
  logic one_shot;
  logic [D_W-1:0] rl_next;
  logic [D_W-1:0] cnt_next;

  assign enabled  = rl_q[RL_EN];
  assign one_shot = rl_q[RL_ONE];
  assign expire   = tick & enabled & at_expiry(cnt_q);

  // Reload register: a bus write wins; a one-shot expiry drops the enable
  always_comb begin
    rl_next = rl_q;
    if (rl_wr) begin
      rl_next = wdata;
    end else if (expire && one_shot) begin
      rl_next[RL_EN] = 1'b0;
    end
  end

  // Count: immediate load only while disabled, otherwise at expiry
  always_comb begin
    cnt_next = cnt_q;
    if (rl_wr && !enabled) begin
      cnt_next = eff_reload(wdata);
    end else if (expire) begin
      cnt_next = one_shot ? '0 : eff_reload(rl_wr ? wdata : rl_q);
    end else if (tick && enabled) begin
      cnt_next = step_down(cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_q  <= '0;
      cnt_q <= '0;
    end else begin
      rl_q  <= rl_next;
      cnt_q <= cnt_next;
    end
  end

endmodule

// File: rtl/dit_status.sv
module dit_status
  import dit_pkg::*;
#(
  parameter int D_W = DW,
  parameter int N_T = NT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_T-1:0] expire,
  input  logic           ts_wrap,
  input  logic           wr_st,
  input  logic [N_T:0]   clr_bits,
  output logic [N_T-1:0] irq,
  output logic [D_W-1:0] stat_word
);

  localparam int PW = N_T + 1;

  logic [PW-1:0] pend_q;
  logic [PW-1:0] set_v;
  logic [PW-1:0] clr_v;

  assign set_v = {ts_wrap, expire};
  assign clr_v = wr_st ? clr_bits : '0;

  // Set dominates a same-cycle clear so no event is lost
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_v) | set_v;
  end

  assign irq       = pend_q[N_T-1:0];
  assign stat_word = {{(D_W-PW){1'b0}}, pend_q};

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int DATA_W = DW,
  parameter int N_TMR  = NT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_TMR-1:0]  tmr_irq
);

  // Named internal events, visible to the bound checker
  logic                       wr_ts;
  logic [N_TMR-1:0]           wr_rl;
  logic                       wr_st;
  logic [DATA_W-1:0]          ts_q;
  logic                       ts_wrap;
  logic [N_TMR-1:0][DATA_W-1:0] cnt_q;
  logic [N_TMR-1:0][DATA_W-1:0] rl_q;
  logic [N_TMR-1:0]           expire;
  logic [DATA_W-1:0]          stat_word;

  dit_regdec #(.A_W(ADDR_W), .D_W(DATA_W), .N_T(N_TMR)) u_regdec (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .ts_q      (ts_q),
    .cnt_q     (cnt_q),
    .rl_q      (rl_q),
    .stat_word (stat_word),
    .wr_ts     (wr_ts),
    .wr_rl     (wr_rl),
    .wr_st     (wr_st),
    .rdata     (bus_rdata)
  );

  dit_tstamp #(.D_W(DATA_W)) u_tstamp (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_ts   (wr_ts),
    .wdata   (bus_wdata),
    .ts_q    (ts_q),
    .ts_wrap (ts_wrap)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    dit_interval #(.D_W(DATA_W)) u_interval (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .rl_wr  (wr_rl[g]),
      .wdata  (bus_wdata),
      .rl_q   (rl_q[g]),
      .cnt_q  (cnt_q[g]),
      .expire (expire[g])
    );
  end

  dit_status #(.D_W(DATA_W), .N_T(N_TMR)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire),
    .ts_wrap   (ts_wrap),
    .wr_st     (wr_st),
    .clr_bits  (bus_wdata[N_TMR:0]),
    .irq       (tmr_irq),
    .stat_word (stat_word)
  );

endmodule

// File: rtl/dit_checks.sv
module dit_checks
  import dit_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 wr_ts,
  input logic [NT-1:0]        wr_rl,
  input logic                 wr_st,
  input logic [DW-1:0]        wdata,
  input logic [DW-1:0]        ts_q,
  input logic [NT-1:0][DW-1:0] cnt_q,
  input logic [NT-1:0][DW-1:0] rl_q,
  input logic [NT-1:0]        expire,
  input logic [DW-1:0]        stat_word,
  input logic [NT-1:0]        irq
);

  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_ts && ts_q != '1 |=> ts_q == $past(ts_q) + DW'(1)); // R2

  AST_TS_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !wr_ts && ts_q == '1 |=> ts_q == '0 && stat_word[2]); // R4

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] && !rl_q[0][1] && !wr_rl[0] |=> cnt_q[0] == {rl_q[0][DW-1:2], 2'b00}); // R6

  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    expire[1] && rl_q[1][1] && !wr_rl[1] |=> !rl_q[1][0] && cnt_q[1] == '0); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rl_q[0][0] && !wr_rl[0] |=> $stable(cnt_q[0])); // R9

  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st && wdata[0] && !expire[0] |=> !irq[0]); // R10

  AST_EXPIRY_IRQ_A: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> irq[0]); // R11

  AST_EXPIRY_IRQ_B: assert property (@(posedge clk) disable iff (!rst_n)
    expire[1] |=> irq[1]); // R11

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq[0] && !(wr_st && wdata[0]) |=> irq[0]); // R11

endmodule

bind dual_interval_timer dit_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_ts     (wr_ts),
  .wr_rl     (wr_rl),
  .wr_st     (wr_st),
  .wdata     (bus_wdata),
  .ts_q      (ts_q),
  .cnt_q     (cnt_q),
  .rl_q      (rl_q),
  .expire    (expire),
  .stat_word (stat_word),
  .irq       (tmr_irq)
);

// File: tb/test_dual_interval_timer.sv
`timescale 1ns/1ps
module test_dual_interval_timer;

  localparam logic [7:0] A_TS   = 8'h00;
  localparam logic [7:0] A_C1   = 8'h04;
  localparam logic [7:0] A_R1   = 8'h08;
  localparam logic [7:0] A_C2   = 8'h0C;
  localparam logic [7:0] A_R2   = 8'h10;
  localparam logic [7:0] A_WDG  = 8'h14;
  localparam logic [7:0] A_ST   = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  tmr_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_interval_timer i_dual_interval_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tmr_irq   (tmr_irq)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic bus_write(logic [7:0] a, logic [31:0] d, logic with_tick = 1'b0);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = with_tick;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic expect_reg(string req, string what, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, what, v, exp);
  endtask

  task automatic run_ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    expect_reg("R1", "timestamp", A_TS, 32'h0);
    expect_reg("R1", "count1", A_C1, 32'h0);
    expect_reg("R1", "reload1", A_R1, 32'h0);
    expect_reg("R1", "count2", A_C2, 32'h0);
    expect_reg("R1", "reload2", A_R2, 32'h0);
    expect_reg("R1", "status", A_ST, 32'h0);
    check("R1", "irq", {30'h0, tmr_irq}, 32'h0);
  endtask

  task automatic t_timestamp;
    run_ticks(10);
    expect_reg("R2", "after 10 ticks", A_TS, 32'd10);
    idle(5);
    expect_reg("R2", "holds without tick", A_TS, 32'd10);
    bus_write(A_TS, 32'h0);
    expect_reg("R3", "zero write restarts", A_TS, 32'h0);
    bus_write(A_TS, 32'h1234, 1'b1);
    expect_reg("R3", "write beats tick", A_TS, 32'h1234);
  endtask

  task automatic t_wrap;
    bus_write(A_TS, 32'hFFFF_FFFD);
    run_ticks(2);
    expect_reg("R2", "near wrap", A_TS, 32'hFFFF_FFFF);
    expect_reg("R4", "no flag before wrap", A_ST, 32'h0);
    run_ticks(1);
    expect_reg("R4", "wrapped to zero", A_TS, 32'h0);
    expect_reg("R4", "wrap flag", A_ST, 32'h4);
    check("R11", "no timer irq on wrap", {30'h0, tmr_irq}, 32'h0);
    bus_write(A_ST, 32'h4);
    expect_reg("R10", "wrap flag cleared", A_ST, 32'h0);
  endtask

  task automatic t_periodic;
    bus_write(A_R1, 32'h0000_000D);           // 12, enabled, periodic
    expect_reg("R5", "reload readback", A_R1, 32'hD);
    expect_reg("R5", "masked count", A_C1, 32'd12);
    run_ticks(11);
    expect_reg("R6", "count before expiry", A_C1, 32'd1);
    check("R11", "irq low before expiry", {31'h0, tmr_irq[0]}, 32'h0);
    run_ticks(1);
    expect_reg("R6", "reloaded", A_C1, 32'd12);
    check("R11", "irq on expiry", {31'h0, tmr_irq[0]}, 32'h1);
    expect_reg("R6", "pending bit 0", A_ST, 32'h1);
    run_ticks(5);
    check("R11", "irq held", {31'h0, tmr_irq[0]}, 32'h1);
    bus_write(A_ST, 32'h0);
    check("R10", "zero write keeps", {31'h0, tmr_irq[0]}, 32'h1);
    bus_write(A_ST, 32'h2);
    check("R10", "other bit keeps", {31'h0, tmr_irq[0]}, 32'h1);
    bus_write(A_ST, 32'h1);
    check("R10", "one write clears", {31'h0, tmr_irq[0]}, 32'h0);
    run_ticks(6);
    check("R6", "second period not yet", {31'h0, tmr_irq[0]}, 32'h0);
    run_ticks(1);
    check("R6", "second period expiry", {31'h0, tmr_irq[0]}, 32'h1);
    expect_reg("R6", "second reload", A_C1, 32'd12);
    bus_write(A_ST, 32'h1);
  endtask

  task automatic t_live_reload;
    run_ticks(4);
    expect_reg("R6", "counting down", A_C1, 32'd8);
    bus_write(A_R1, 32'h0000_0021);           // 32, enabled, periodic
    expect_reg("R8", "running count untouched", A_C1, 32'd8);
    run_ticks(8);
    expect_reg("R8", "new value at expiry", A_C1, 32'd32);
    check("R8", "expiry irq", {31'h0, tmr_irq[0]}, 32'h1);
    bus_write(A_ST, 32'h1);
  endtask

  task automatic t_disable;
    run_ticks(3);
    expect_reg("R6", "count 29", A_C1, 32'd29);
    bus_write(A_R1, 32'h0);
    run_ticks(10);
    expect_reg("R9", "count frozen", A_C1, 32'd29);
    check("R9", "no irq while off", {31'h0, tmr_irq[0]}, 32'h0);
    bus_write(A_R1, 32'h0000_0009);           // 8, enabled
    expect_reg("R8", "immediate load", A_C1, 32'd8);
    bus_write(A_R1, 32'h0);
    run_ticks(4);
    expect_reg("R9", "frozen at 8", A_C1, 32'd8);
  endtask

  task automatic t_oneshot;
    bus_write(A_R2, 32'h0000_0013);           // 16, enabled, one-shot
    expect_reg("R5", "one-shot count", A_C2, 32'd16);
    run_ticks(15);
    check("R7", "irq2 before expiry", {31'h0, tmr_irq[1]}, 32'h0);
    run_ticks(1);
    check("R7", "irq2 on expiry", {31'h0, tmr_irq[1]}, 32'h1);
    expect_reg("R7", "enable dropped", A_R2, 32'h12);
    expect_reg("R7", "count zero", A_C2, 32'h0);
    bus_write(A_ST, 32'h2);
    run_ticks(20);
    check("R7", "no retrigger", {30'h0, tmr_irq}, 32'h0);
    expect_reg("R7", "still zero", A_C2, 32'h0);
  endtask

  task automatic t_readonly;
    bus_write(A_C1, 32'h55);
    expect_reg("R12", "count1 write ignored", A_C1, 32'd8);
    bus_write(A_C2, 32'h77);
    expect_reg("R12", "count2 write ignored", A_C2, 32'h0);
    expect_reg("R12", "unmapped reads zero", A_WDG, 32'h0);
  endtask

  task automatic t_set_wins;
    bus_write(A_R2, 32'h0000_0005);           // 4, enabled, periodic
    run_ticks(3);
    expect_reg("R6", "count 1", A_C2, 32'd1);
    bus_write(A_ST, 32'h1A, 1'b1);           // clear bit1 plus bits 3,4 while expiring
    check("R10", "set beats clear", {31'h0, tmr_irq[1]}, 32'h1);
    expect_reg("R10", "reserved bits zero", A_ST, 32'h2);
    bus_write(A_R2, 32'h0);
    bus_write(A_ST, 32'h2);
    check("R10", "cleared", {30'h0, tmr_irq}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_timestamp();
    t_wrap();
    t_periodic();
    t_live_reload();
    t_disable();
    t_oneshot();
    t_readonly();
    t_set_wins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule